// File: doc/BRIEF.md
# Virtual Channel Request Policy Filter

This block sits on the inbound side of a host bridge and makes a policy decision for every request that arrives. A request carries a 2-bit channel identifier, a transaction kind, a no-snoop hint, an address and byte enables. There are three channels: the default channel, a priority-snoop channel and an isochronous channel. For each request the block produces exactly one routing verdict:

- forward to the cache/snoop path,
- forward peer to peer,
- convert to an interrupt toward the cores,
- forward as a message,
- reject as unsupported.

It also produces the snoop requirement, the snoop priority, the final address and the final byte enables.

Each channel follows its own rule table. A write that is not allowed on the priority channel is turned into a harmless write: it goes to a fixed address with every byte enable cleared. A read that is not allowed there goes to the same fixed address and is answered with an unsupported-request completion. The two optional channels are gated by enable inputs. A sticky error flag records every unsupported verdict until a clear pulse is given.

The verdict is registered. It appears one cycle after the request is accepted, behind a valid/ready handshake on both sides.

Top module: `vcf_filter`

## Requirements
- R1: A request accepted at a clock edge (in_valid and in_ready both high) produces out_valid at that same edge, holding its verdict. in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, every output field stays unchanged.
- R2: Channel codes are 0 = default channel, 1 = priority channel, 2 = isochronous channel, and 3 = reserved. A request on code 3, on code 1 while en_prio is low, or on code 2 while en_iso is low is rejected.
- R3: Kind codes are 0 memory read, 1 memory write, 2 peer read, 3 peer write, 4 aperture read, 5 aperture write, 6 MSI, 7 legacy-wire message, 8 MCTP message, and 9 to 15 reserved (always rejected). Route codes are 0 cache, 1 peer, 2 interrupt, 3 message, 4 reject. A reject has ur=1, snoop=0, prio=0, address 0x000C_0000 and byte enables 0.
- R4: On channel 0, memory reads and writes route to cache with snoop = not no-snoop, prio 0, and the address and byte enables passed unchanged.
- R5: On channel 0, aperture writes route to cache with snoop 0 whatever the no-snoop hint says. Aperture reads are rejected.
- R6: On channel 0, peer reads, peer writes and MCTP messages route to peer with snoop 0, ignoring the no-snoop hint.
- R7: MSI routes to interrupt on channels 0 and 1. Legacy-wire messages route to message on channel 0. Both have snoop 0 and ignore the no-snoop hint.
- R8: On channel 1, memory reads and writes route to cache with snoop 1 and prio 1 whatever the no-snoop hint says, with address and byte enables passed unchanged.
- R9: On channel 1, peer writes and aperture writes route to cache with address 0x000C_0000, byte enables 0, ur 0, snoop 1 and prio 1.
- R10: On channel 1, peer reads and aperture reads route to cache with address 0x000C_0000, byte enables 0, ur 1, snoop 1 and prio 1.
- R11: On channel 1, legacy-wire and MCTP messages are rejected.
- R12: On channel 2, only memory reads and writes with the no-snoop hint set are accepted. They route to cache with snoop 0, prio 0, and the address and byte enables unchanged. Every other request on channel 2 is rejected.
- R13: err_flag goes high at the edge that accepts a request whose verdict has ur=1. It stays high until an edge with err_clr high. If a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_prio | input | 1 | Enables the priority-snoop channel |
| en_iso | input | 1 | Enables the isochronous channel |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_vc | input | 2 | Channel code |
| in_kind | input | 4 | Transaction kind code |
| in_nosnoop | input | 1 | No-snoop hint from the request |
| in_addr | input | ADDR_W | Request address |
| in_be | input | BE_W | Request byte enables |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Verdict taken downstream |
| out_route | output | 3 | Route code |
| out_snoop | output | 1 | Snoop required |
| out_prio | output | 1 | High snoop priority |
| out_ur | output | 1 | Unsupported-request completion owed |
| out_addr | output | ADDR_W | Final address |
| out_be | output | BE_W | Final byte enables |
| err_clr | input | 1 | Clear pulse for the sticky error flag |
| err_flag | output | 1 | Sticky unsupported-request flag |

## Verification
Two things can land on one edge:

- A software clear of the sticky error flag and the acceptance of a new request whose verdict is unsupported.
- A stalled verdict being drained while the next request is loaded.

The bench raises err_clr in the same cycle as an unsupported request and expects the flag to remain set. It also pairs a clear with a supported request and expects the flag to drop. For the drain case, it holds out_ready low with a second request waiting. It then releases out_ready and expects the second verdict on the very next edge, with no idle cycle in between.

// File: rtl/vcf_pkg.sv
package vcf_pkg;

    typedef enum logic [1:0] {
        VC_BASE = 2'd0,
        VC_PRIO = 2'd1,
        VC_ISO  = 2'd2,
        VC_RSVD = 2'd3
    } vc_e;

    typedef enum logic [3:0] {
        K_MRD  = 4'd0,
        K_MWR  = 4'd1,
        K_PRD  = 4'd2,
        K_PWR  = 4'd3,
        K_GRD  = 4'd4,
        K_GWR  = 4'd5,
        K_MSI  = 4'd6,
        K_VLW  = 4'd7,
        K_MCTP = 4'd8
    } kind_e;

    typedef enum logic [2:0] {
        RT_CACHE  = 3'd0,
        RT_PEER   = 3'd1,
        RT_INTR   = 3'd2,
        RT_MSG    = 3'd3,
        RT_REJECT = 3'd4
    } route_e;

    typedef struct packed {
        route_e route;
        logic   snoop;
        logic   prio;
        logic   ur;
        logic   remap;
    } verdict_t;

    function automatic verdict_t mk_verdict(route_e r, logic sn, logic pr, logic ur, logic rm);
        verdict_t v;
        v.route = r;
        v.snoop = sn;
        v.prio  = pr;
        v.ur    = ur;
        v.remap = rm;
        return v;
    endfunction

    localparam verdict_t REJECT_VERDICT = '{route: RT_REJECT, snoop: 1'b0, prio: 1'b0,
                                           ur: 1'b1, remap: 1'b1};

endpackage

// File: rtl/vcf_chan_gate.sv
module vcf_chan_gate
    import vcf_pkg::*;
(
    input  logic [1:0] vc,
    input  logic       en_prio,
    input  logic       en_iso,
    output logic       chan_ok
);
    always_comb begin
        unique case (vc)
            VC_BASE: chan_ok = 1'b1;
            VC_PRIO: chan_ok = en_prio;
            VC_ISO:  chan_ok = en_iso;
            default: chan_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/vcf_decide.sv
module vcf_decide
    import vcf_pkg::*;
(
    input  logic       chan_ok,
    input  logic [1:0] vc,
    input  logic [3:0] kind,
    input  logic       nosnoop,
    output verdict_t   verdict
);
    verdict_t base_v;
    verdict_t prio_v;
    verdict_t iso_v;

    // default channel table
    always_comb begin
        base_v = REJECT_VERDICT;
        case (kind)
            K_MRD, K_MWR:        base_v = mk_verdict(RT_CACHE, ~nosnoop, 1'b0, 1'b0, 1'b0);
            K_GWR:               base_v = mk_verdict(RT_CACHE, 1'b0, 1'b0, 1'b0, 1'b0);
            K_PRD, K_PWR, K_MCTP: base_v = mk_verdict(RT_PEER, 1'b0, 1'b0, 1'b0, 1'b0);
            K_MSI:               base_v = mk_verdict(RT_INTR, 1'b0, 1'b0, 1'b0, 1'b0);
            K_VLW:               base_v = mk_verdict(RT_MSG, 1'b0, 1'b0, 1'b0, 1'b0);
            default:             base_v = REJECT_VERDICT;
        endcase
    end

    // priority-snoop channel table
    always_comb begin
        prio_v = REJECT_VERDICT;
        case (kind)
            K_MRD, K_MWR: prio_v = mk_verdict(RT_CACHE, 1'b1, 1'b1, 1'b0, 1'b0);
            K_PWR, K_GWR: prio_v = mk_verdict(RT_CACHE, 1'b1, 1'b1, 1'b0, 1'b1);
            K_PRD, K_GRD: prio_v = mk_verdict(RT_CACHE, 1'b1, 1'b1, 1'b1, 1'b1);
            K_MSI:        prio_v = mk_verdict(RT_INTR, 1'b0, 1'b0, 1'b0, 1'b0);
            default:      prio_v = REJECT_VERDICT;
        endcase
    end

    // isochronous channel table
    always_comb begin
        iso_v = REJECT_VERDICT;
        if (nosnoop && (kind == K_MRD || kind == K_MWR))
            iso_v = mk_verdict(RT_CACHE, 1'b0, 1'b0, 1'b0, 1'b0);
    end

    always_comb begin
        verdict = REJECT_VERDICT;
        if (chan_ok) begin
            case (vc)
                VC_BASE: verdict = base_v;
                VC_PRIO: verdict = prio_v;
                VC_ISO:  verdict = iso_v;
                default: verdict = REJECT_VERDICT;
            endcase
        end
    end
endmodule

// File: rtl/vcf_filter.sv
module vcf_filter
    import vcf_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter int               BE_W       = 4,
    parameter logic [ADDR_W-1:0] REMAP_ADDR = ADDR_W'(32'h000C_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_prio,
    input  logic              en_iso,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_vc,
    input  logic [3:0]        in_kind,
    input  logic              in_nosnoop,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_route,
    output logic              out_snoop,
    output logic              out_prio,
    output logic              out_ur,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BE_W-1:0]   out_be,
    input  logic              err_clr,
    output logic              err_flag
);
    localparam int ST_W = 1 + $bits(verdict_t) + ADDR_W + BE_W + 1;

    typedef struct packed {
        logic              vld;
        verdict_t          vd;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic              err;
    } state_t;

    state_t   st_d, st_q;
    logic     chan_ok;
    verdict_t verdict;
    logic     accept;

    vcf_chan_gate u_gate (
        .vc      (in_vc),
        .en_prio (en_prio),
        .en_iso  (en_iso),
        .chan_ok (chan_ok)
    );

    vcf_decide u_decide (
        .chan_ok (chan_ok),
        .vc      (in_vc),
        .kind    (in_kind),
        .nosnoop (in_nosnoop),
        .verdict (verdict)
    );

    assign in_ready = ~st_q.vld | out_ready;
    assign accept   = in_valid & in_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready)
            st_d.vld = 1'b0;
        if (accept) begin
            st_d.vld  = 1'b1;
            st_d.vd   = verdict;
            st_d.addr = verdict.remap ? REMAP_ADDR : in_addr;
            st_d.be   = verdict.remap ? '0 : in_be;
        end
        if (err_clr)
            st_d.err = 1'b0;
        if (accept && verdict.ur)
            st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= ST_W'(0);
            st_q.vd.route <= RT_REJECT;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_route = st_q.vd.route;
    assign out_snoop = st_q.vd.snoop;
    assign out_prio  = st_q.vd.prio;
    assign out_ur    = st_q.vd.ur;
    assign out_addr  = st_q.addr;
    assign out_be    = st_q.be;
    assign err_flag  = st_q.err;
endmodule

// File: rtl/vcf_filter_chk.sv
module vcf_filter_chk #(
    parameter int               ADDR_W     = 32,
    parameter int               BE_W       = 4,
    parameter logic [ADDR_W-1:0] REMAP_ADDR = ADDR_W'(32'h000C_0000)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_prio,
    input logic              en_iso,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_vc,
    input logic [3:0]        in_kind,
    input logic              in_nosnoop,
    input logic              out_valid,
    input logic              out_ready,
    input logic [2:0]        out_route,
    input logic              out_snoop,
    input logic              out_prio,
    input logic              out_ur,
    input logic [ADDR_W-1:0] out_addr,
    input logic [BE_W-1:0]   out_be,
    input logic              err_flag
);
    // R1: stalled verdict is held unchanged
    a_r1_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_route) && $stable(out_addr)
                                    && $stable(out_be) && $stable(out_ur));

    // R1: accepted request always yields a verdict next cycle
    a_r1_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R3: a reject always carries the unsupported form
    a_r3_reject_form: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_route == 3'd4 |-> out_ur && !out_snoop && !out_prio
                                           && out_addr == REMAP_ADDR && out_be == '0);

    // R10: every unsupported verdict points at the fixed address with no byte enables
    a_r10_ur_remapped: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ur |-> out_addr == REMAP_ADDR && out_be == '0);

    // R8: high priority only ever accompanies a snoop
    a_r8_prio_snooped: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_prio |-> out_snoop);

    // R2: reserved channel code is rejected
    a_r2_rsvd_vc: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_vc == 2'd3 |=> out_route == 3'd4);

    // R12: snooped request on the enabled isochronous channel is unsupported
    a_r12_iso_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && en_iso && in_vc == 2'd2 && !in_nosnoop |=> out_ur);

    // R13: an unsupported verdict just accepted has set the sticky flag
    a_r13_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> (!out_ur || err_flag));

    // R8: memory traffic on the enabled priority channel is snooped at high priority
    a_r8_prio_mem: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && en_prio && in_vc == 2'd1 && in_kind <= 4'd1
        |=> out_snoop && out_prio);
endmodule

bind vcf_filter vcf_filter_chk #(
    .ADDR_W     (ADDR_W),
    .BE_W       (BE_W),
    .REMAP_ADDR (REMAP_ADDR)
) u_vcf_filter_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_prio    (en_prio),
    .en_iso     (en_iso),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_vc      (in_vc),
    .in_kind    (in_kind),
    .in_nosnoop (in_nosnoop),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_route  (out_route),
    .out_snoop  (out_snoop),
    .out_prio   (out_prio),
    .out_ur     (out_ur),
    .out_addr   (out_addr),
    .out_be     (out_be),
    .err_flag   (err_flag)
);

// File: tb/vcf_filter_bench.sv
`timescale 1ns/1ps
module vcf_filter_bench;
    localparam int ADDR_W = 32;
    localparam int BE_W   = 4;
    localparam logic [31:0] FIX = 32'h000C_0000;
    localparam logic [31:0] TA  = 32'h1234_5678;
    localparam logic [3:0]  TB  = 4'hA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_prio = 1'b1, en_iso = 1'b1;
    logic in_valid = 1'b0, in_nosnoop = 1'b0;
    logic [1:0] in_vc = '0;
    logic [3:0] in_kind = '0;
    logic [ADDR_W-1:0] in_addr = TA;
    logic [BE_W-1:0] in_be = TB;
    logic out_ready = 1'b1, err_clr = 1'b0;
    logic in_ready, out_valid, out_snoop, out_prio, out_ur, err_flag;
    logic [2:0] out_route;
    logic [ADDR_W-1:0] out_addr;
    logic [BE_W-1:0] out_be;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vcf_filter u_vcf_filter (
        .clk(clk), .rst_n(rst_n), .en_prio(en_prio), .en_iso(en_iso),
        .in_valid(in_valid), .in_ready(in_ready), .in_vc(in_vc), .in_kind(in_kind),
        .in_nosnoop(in_nosnoop), .in_addr(in_addr), .in_be(in_be),
        .out_valid(out_valid), .out_ready(out_ready), .out_route(out_route),
        .out_snoop(out_snoop), .out_prio(out_prio), .out_ur(out_ur),
        .out_addr(out_addr), .out_be(out_be), .err_clr(err_clr), .err_flag(err_flag)
    );

    task automatic expect_eq(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // route, snoop, prio, ur, addr, be, valid packed for one comparison
    function automatic logic [63:0] pack_out(logic v, logic [2:0] r, logic s, logic p,
                                             logic u, logic [31:0] a, logic [3:0] b);
        return {21'd0, v, r, s, p, u, a, b};
    endfunction

    task automatic xact(string tag, logic [1:0] vc, logic [3:0] kind, logic ns,
                        logic [2:0] er, logic es, logic ep, logic eu, logic rm);
        @(negedge clk);
        in_vc = vc; in_kind = kind; in_nosnoop = ns; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        expect_eq(tag, pack_out(out_valid, out_route, out_snoop, out_prio, out_ur, out_addr, out_be),
                  pack_out(1'b1, er, es, ep, eu, rm ? FIX : TA, rm ? 4'h0 : TB));
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        expect_eq("R1 reset state", {61'd0, out_valid, err_flag, in_ready}, {61'd0, 1'b0, 1'b0, 1'b1});
    endtask

    task automatic t_base();
        xact("R4 vc0 mem read snooped",    2'd0, 4'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        xact("R4 vc0 mem write nosnoop",   2'd0, 4'd1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R5 vc0 aperture write",      2'd0, 4'd5, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R5 vc0 aperture read",       2'd0, 4'd4, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        xact("R6 vc0 peer write",          2'd0, 4'd3, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R6 vc0 peer read",           2'd0, 4'd2, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R6 vc0 mctp",                2'd0, 4'd8, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R7 vc0 msi",                 2'd0, 4'd6, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R7 vc0 legacy wire",         2'd0, 4'd7, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R3 reserved kind",           2'd0, 4'd9, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_prio();
        xact("R8 vcp mem read nosnoop",    2'd1, 4'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        xact("R8 vcp mem write",           2'd1, 4'd1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        xact("R9 vcp peer write",          2'd1, 4'd3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        xact("R9 vcp aperture write",      2'd1, 4'd5, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        xact("R10 vcp peer read",          2'd1, 4'd2, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        xact("R10 vcp aperture read",      2'd1, 4'd4, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        xact("R7 vcp msi",                 2'd1, 4'd6, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R11 vcp legacy wire",        2'd1, 4'd7, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        xact("R11 vcp mctp",               2'd1, 4'd8, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_iso();
        xact("R12 vc1 mem read nosnoop",   2'd2, 4'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R12 vc1 mem write nosnoop",  2'd2, 4'd1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        xact("R12 vc1 snooped read",       2'd2, 4'd0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        xact("R12 vc1 msi",                2'd2, 4'd6, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        xact("R12 vc1 peer write",         2'd2, 4'd3, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_disabled();
        en_prio = 1'b0; en_iso = 1'b0;
        xact("R2 vcp disabled",            2'd1, 4'd0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        xact("R2 vc1 disabled",            2'd2, 4'd0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        en_prio = 1'b1; en_iso = 1'b1;
        xact("R2 reserved channel",        2'd3, 4'd0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_stall();
        @(negedge clk);
        out_ready = 1'b0;
        in_vc = 2'd0; in_kind = 4'd6; in_nosnoop = 1'b0; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_kind = 4'd7;
        expect_eq("R1 stalled in_ready low", {63'd0, in_ready}, 64'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        expect_eq("R1 stalled verdict held", {60'd0, out_valid, out_route}, {60'd0, 1'b1, 3'd2});
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        expect_eq("R1 drain and load same edge", {60'd0, out_valid, out_route}, {60'd0, 1'b1, 3'd3});
    endtask

    task automatic t_err();
        xact("R13 ur sets flag pre",       2'd3, 4'd0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_eq("R13 flag set by ur", {63'd0, err_flag}, 64'd1);
        @(negedge clk);
        err_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        err_clr = 1'b0;
        expect_eq("R13 flag cleared", {63'd0, err_flag}, 64'd0);
        xact("R13 supported leaves flag",  2'd0, 4'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_eq("R13 flag stays clear", {63'd0, err_flag}, 64'd0);
        err_clr = 1'b1;
        xact("R13 ur with clear",          2'd0, 4'd4, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_eq("R13 set wins over clear", {63'd0, err_flag}, 64'd1);
        xact("R13 clear with good req",    2'd0, 4'd1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        err_clr = 1'b0;
        expect_eq("R13 clear with supported", {63'd0, err_flag}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_base();
        t_prio();
        t_iso();
        t_disabled();
        t_stall();
        t_err();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule